// File: doc/BRIEF.md
# Packed-Window Address Translator

The translator turns a host-side virtual address into a physical address through a small set of programmable windows. Software sets a physical start for every window and a size for every window except the last. The windows sit back to back in virtual space in a fixed order, beginning at address zero. Each window's virtual base is therefore the running total of the sizes of the windows before it.

There are four windows by default: three memory windows and one register window. Window 0 begins at virtual address zero. Window 1 is the register window and follows window 0. Window 2 follows window 1. Window 3 has no size register and takes every address above the end of window 2. A second build variant leaves this open tail out. In that variant, addresses past window 2 raise a miss flag.

The physical output is combinational from the virtual address and the configuration registers. A configuration write lands on the clock edge, so the new mapping is used from the next cycle onward.

Top module: `addr_window_xlate`

## Requirements
- R1: A virtual address v with v < size0 translates to start0 + v.
- R2: A virtual address v with size0 <= v < size0+size1 translates to start1 + (v - size0).
- R3: A virtual address v with size0+size1 <= v < size0+size1+size2 translates to start2 + (v - size0 - size1).
- R4: With the open tail enabled (TAIL_OPEN=1), any v >= size0+size1+size2 translates to start3 + (v - size0 - size1 - size2), truncated to 32 bits, and miss stays 0.
- R5: A window of size zero claims no address. Addresses at its base go to the next window in order, and at most one window is selected at a time.
- R6: With the open tail disabled (TAIL_OPEN=0), miss is 1 exactly for v >= size0+size1+size2. Otherwise miss is 0 and the translation follows R1 to R3.
- R7: Configuration select encoding: cfg_sel[2:1] names the window and cfg_sel[0] picks the field (0 = start, 1 = size). The code 3'b111 (size of window 3) has no register, and a write to it changes no translation.
- R8: A write with cfg_we=1 at a rising edge changes the translation only after that edge. Before the edge the old value is still in use.
- R9: A synchronous active-low reset clears every start and size register to zero. After reset with the open tail, every address translates to itself and miss is 0.
- R10: Window ends are added up without wrapping at 32 bits. For example, with size0=0xF000_0000 and size1=0x2000_0000, address 0xFFFF_FFFF lies in window 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select: window in [2:1], field in [0] |
| cfg_wdata | input | 32 | Configuration write data |
| vaddr | input | 32 | Virtual address to translate |
| paddr | output | 32 | Translated physical address |
| miss | output | 1 | No window holds vaddr |

## Verification
The assertions assume that cfg_we, cfg_sel and cfg_wdata are known and stable around each rising edge. They also assume that vaddr settles before the outputs are sampled, since the translation path has no register. The bench changes every input on the falling edge and samples half a cycle later. Configuration changes are made only through single-cycle write pulses. The bench chooses window sizes whose running total stays below 2^32, except in the one test that probes the no-wrap rule.

// File: rtl/addr_window_pkg.sv
// Shared definitions for the packed-window address translator.
// Assumes: one address width for virtual and physical space.
package addr_window_pkg;
    localparam int unsigned AW_DEFAULT   = 32;
    localparam int unsigned NWIN_DEFAULT = 4;

    // Field picked by the low select bit
    typedef enum logic {
        FLD_START = 1'b0,
        FLD_SIZE  = 1'b1
    } win_field_e;
endpackage

// File: rtl/addr_window_cfg.sv
// Holds the start register of every window and the size register of
// every window but the last. Writes land on the rising edge.
// Assumes: cfg_sel upper bits name the window, bit 0 names the field.
module addr_window_cfg
    import addr_window_pkg::*;
#(
    parameter int unsigned AW   = AW_DEFAULT,
    parameter int unsigned NWIN = NWIN_DEFAULT,
    localparam int unsigned WIN_W = (NWIN > 1) ? $clog2(NWIN) : 1,
    localparam int unsigned SEL_W = WIN_W + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [SEL_W-1:0]          cfg_sel,
    input  logic [AW-1:0]             cfg_wdata,
    output logic [NWIN-1:0][AW-1:0]   start_o,
    output logic [NWIN-2:0][AW-1:0]   size_o
);
    logic [WIN_W-1:0] sel_win;
    win_field_e       sel_fld;

    // Split the select into window index and field
    always_comb begin
        sel_win = cfg_sel[SEL_W-1:1];
        sel_fld = win_field_e'(cfg_sel[0]);
    end

    // Register file update: reset to zero, single-field write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_o <= '0;
            size_o  <= '0;
        end else if (cfg_we) begin
            for (int i = 0; i < int'(NWIN); i++) begin
                if (sel_win == WIN_W'(i)) begin
                    if (sel_fld == FLD_START)
                        start_o[i] <= cfg_wdata;
                    else if (i < int'(NWIN) - 1)
                        size_o[i] <= cfg_wdata;
                end
            end
        end
    end

    // R9: reset clears the whole register set
    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> (start_o == '0 && size_o == '0));

    // R7: the missing size field of the last window is a no-op
    p_bad_sel_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == {WIN_W'(NWIN - 1), 1'b1})
        |=> ($stable(start_o) && $stable(size_o)));

    // R8: a write lands exactly one edge later
    for (genvar g = 0; g < int'(NWIN); g++) begin : g_chk_start
        p_start_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_sel == {WIN_W'(g), 1'b0})
            |=> (start_o[g] == $past(cfg_wdata)));
    end
    for (genvar g = 0; g < int'(NWIN) - 1; g++) begin : g_chk_size
        p_size_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_sel == {WIN_W'(g), 1'b1})
            |=> (size_o[g] == $past(cfg_wdata)));
    end
endmodule

// File: rtl/addr_window_decode.sv
// Builds each window's virtual base as the running sum of earlier sizes
// and flags which window holds the address. Sums use extra bits so
// that no window end wraps around the address space.
// Assumes: sizes are unsigned byte counts; a zero size means empty.
module addr_window_decode
    import addr_window_pkg::*;
#(
    parameter int unsigned AW        = AW_DEFAULT,
    parameter int unsigned NWIN      = NWIN_DEFAULT,
    parameter bit          TAIL_OPEN = 1'b1,
    localparam int unsigned EW = AW + ((NWIN > 1) ? $clog2(NWIN) : 1)
) (
    input  logic [AW-1:0]             vaddr,
    input  logic [NWIN-2:0][AW-1:0]   size_i,
    output logic [NWIN-1:0][AW-1:0]   base_o,
    output logic [NWIN-1:0]           hit_o
);
    logic [NWIN-1:0][EW-1:0] base_w;
    logic [EW-1:0]           vx;

    // Running base chain, one adder per window boundary
    always_comb begin
        base_w[0] = '0;
        for (int i = 1; i < int'(NWIN); i++)
            base_w[i] = base_w[i-1] + EW'(size_i[i-1]);
    end

    // Range compare per window against the widened address
    always_comb begin
        vx = EW'(vaddr);
        for (int i = 0; i < int'(NWIN); i++) begin
            base_o[i] = base_w[i][AW-1:0];
            if (i < int'(NWIN) - 1)
                hit_o[i] = (vx >= base_w[i]) && (vx < base_w[i+1]);
            else
                hit_o[i] = TAIL_OPEN && (vx >= base_w[i]);
        end
    end
endmodule

// File: rtl/addr_window_rebase.sv
// Rebases the virtual address onto the selected window's physical start
// and raises miss when no window is selected.
// Assumes: hit_i is one-hot or zero.
module addr_window_rebase
    import addr_window_pkg::*;
#(
    parameter int unsigned AW   = AW_DEFAULT,
    parameter int unsigned NWIN = NWIN_DEFAULT
) (
    input  logic [AW-1:0]             vaddr,
    input  logic [NWIN-1:0]           hit_i,
    input  logic [NWIN-1:0][AW-1:0]   start_i,
    input  logic [NWIN-1:0][AW-1:0]   base_i,
    output logic [AW-1:0]             paddr_o,
    output logic                      miss_o
);
    // AND-OR select of the rebased candidate of the hit window
    always_comb begin
        paddr_o = '0;
        for (int i = 0; i < int'(NWIN); i++)
            if (hit_i[i])
                paddr_o = paddr_o | (start_i[i] + (vaddr - base_i[i]));
        miss_o = ~|hit_i;
    end
endmodule

// File: rtl/addr_window_xlate.sv
// Top of the packed-window translator: configuration registers,
// range decode and rebasing. The translation path has no register.
// Assumes: vaddr is stable when paddr and miss are used.
module addr_window_xlate
    import addr_window_pkg::*;
#(
    parameter int unsigned AW        = AW_DEFAULT,
    parameter int unsigned NWIN      = NWIN_DEFAULT,
    parameter bit          TAIL_OPEN = 1'b1,
    localparam int unsigned WIN_W = (NWIN > 1) ? $clog2(NWIN) : 1,
    localparam int unsigned SEL_W = WIN_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [AW-1:0]    cfg_wdata,
    input  logic [AW-1:0]    vaddr,
    output logic [AW-1:0]    paddr,
    output logic             miss
);
    logic [NWIN-1:0][AW-1:0] start_q;
    logic [NWIN-2:0][AW-1:0] size_q;
    logic [NWIN-1:0][AW-1:0] base;
    logic [NWIN-1:0]         hit;

    addr_window_cfg #(.AW(AW), .NWIN(NWIN)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .start_o(start_q), .size_o(size_q)
    );

    addr_window_decode #(.AW(AW), .NWIN(NWIN), .TAIL_OPEN(TAIL_OPEN)) u_dec (
        .vaddr(vaddr), .size_i(size_q), .base_o(base), .hit_o(hit)
    );

    addr_window_rebase #(.AW(AW), .NWIN(NWIN)) u_reb (
        .vaddr(vaddr), .hit_i(hit), .start_i(start_q), .base_i(base),
        .paddr_o(paddr), .miss_o(miss)
    );

    // R5: packed windows never overlap
    p_single_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

    // R5: an empty first window never claims an address
    p_empty_win0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (size_q[0] == '0) |-> !hit[0]);

    // R1: the first window is an offset from its start
    p_win0_rebase_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hit[0] |-> (paddr == start_q[0] + vaddr));

    // R4: an open tail leaves no address unmapped
    if (TAIL_OPEN) begin : g_tail_chk
        p_tail_no_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !miss);
    end
endmodule

// File: tb/addr_window_xlate_bench.sv
module addr_window_xlate_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] vaddr = '0;
    logic [31:0] paddr, paddr_c;
    logic        miss, miss_c;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    // vector: {vaddr, expected paddr, expected miss with closed tail}
    localparam logic [64:0] VEC [NVEC] = '{
        {32'h0000_0000, 32'h8000_0000, 1'b0},
        {32'h0000_0FFF, 32'h8000_0FFF, 1'b0},
        {32'h0000_1000, 32'h0030_0000, 1'b0},
        {32'h0000_11FF, 32'h0030_01FF, 1'b0},
        {32'h0000_1200, 32'h1000_0000, 1'b0},
        {32'h0000_51FF, 32'h1000_3FFF, 1'b0},
        {32'h0000_5200, 32'hA000_0000, 1'b1},
        {32'hFFFF_FFFF, 32'h9FFF_ADFF, 1'b1}
    };

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_window_xlate u_addr_window_xlate (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .vaddr(vaddr), .paddr(paddr), .miss(miss)
    );

    addr_window_xlate #(.TAIL_OPEN(1'b0)) u_closed (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .vaddr(vaddr), .paddr(paddr_c), .miss(miss_c)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic probe(input logic [31:0] v);
        @(negedge clk);
        vaddr = v;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: identity mapping after reset
        probe(32'h1234_5678);
        chk("R9 paddr", paddr, 32'h1234_5678);
        chk("R9 miss", {31'b0, miss}, 32'd0);
        chk("R6 closed miss after reset", {31'b0, miss_c}, 32'd1);

        // R7: program windows through the select encoding
        wr(3'b000, 32'h8000_0000);
        wr(3'b001, 32'h0000_1000);
        wr(3'b010, 32'h0030_0000);
        wr(3'b011, 32'h0000_0200);
        wr(3'b100, 32'h1000_0000);
        wr(3'b101, 32'h0000_4000);
        wr(3'b110, 32'hA000_0000);

        // R1 R2 R3 R4 R6: vector walk
        for (int k = 0; k < NVEC; k++) begin
            probe(VEC[k][64:33]);
            chk($sformatf("R1-4 vec%0d paddr", k), paddr, VEC[k][32:1]);
            chk($sformatf("R4 vec%0d open miss", k), {31'b0, miss}, 32'd0);
            chk($sformatf("R6 vec%0d closed miss", k), {31'b0, miss_c}, {31'b0, VEC[k][0]});
            if (!VEC[k][0])
                chk($sformatf("R6 vec%0d closed paddr", k), paddr_c, VEC[k][32:1]);
        end

        // R7: write to the nonexistent size of window 3 is ignored
        wr(3'b111, 32'h0000_0100);
        probe(32'h0000_5200);
        chk("R7 tail base unchanged", paddr, 32'hA000_0000);
        probe(32'h0000_0000);
        chk("R7 window0 unchanged", paddr, 32'h8000_0000);

        // R8: old mapping before the edge, new one after
        @(negedge clk);
        vaddr = 32'h0000_0010;
        cfg_we = 1'b1; cfg_sel = 3'b000; cfg_wdata = 32'h4000_0000;
        #1;
        chk("R8 before edge", paddr, 32'h8000_0010);
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        chk("R8 after edge", paddr, 32'h4000_0010);

        // R5: empty register window hands its base to window 2
        wr(3'b011, 32'h0000_0000);
        probe(32'h0000_1000);
        chk("R5 empty win1 paddr", paddr, 32'h1000_0000);
        chk("R5 empty win1 closed miss", {31'b0, miss_c}, 32'd0);

        // R10: no wrap of window ends
        wr(3'b001, 32'hF000_0000);
        wr(3'b011, 32'h2000_0000);
        wr(3'b101, 32'h0000_0000);
        probe(32'hFFFF_FFFF);
        chk("R10 paddr", paddr, 32'h102F_FFFF);
        chk("R10 closed miss", {31'b0, miss_c}, 32'd0);

        // R9: reset again restores identity
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        probe(32'h0000_0ABC);
        chk("R9 reset again", paddr, 32'h0000_0ABC);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule